// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller with Non-Maskable Path

This block gathers 32 level-sensitive interrupt lines for one processor. Lines 0 to 29 are maskable. Each clock the block samples them into a raw pending word, ANDs that word with a mask written by software, and drives an interrupt request together with a vector code. A single active source gets a vector of its own. When two or more sources are active at the same time, the block sends one shared vector, and the handler reads the masked word to choose which source to serve first. Lines 30 and 31 bypass the mask. They feed a two-bit non-maskable status word, and any set bit in that word raises a separate non-maskable output.

Software reaches the registers over a plain word-addressed bus. Bits [1:0] of the byte address are ignored, and only the mask word accepts writes. Read data is a combinational function of the address and the current register state. All other outputs are registered. Each output reflects the register state that the same clock edge stores, so a change on a line or a mask write shows up on every output one edge later. The bus and status pins are plain signals with no valid/ready flow control, because a register access always completes in the cycle it is presented.

Top module: `vic_nmi_top`

## Requirements
- R1: While reset is high and after it, until the first change, the mask, raw pending, masked pending and NMI status words read 0, and `irq_req_o`, `irq_vec_o` and `nmi_o` are 0.
- R2: Raw pending bit i (i from 0 to 29) equals the level of line i sampled at the last rising edge. Raw bits 30 and 31 always read 0.
- R3: The masked pending word, at word index 2 (byte 0x08), always equals the raw pending word ANDed with the mask.
- R4: A write with word index 0 (byte 0x00) loads the mask with the full 32-bit write data. A write to any other address leaves every register unchanged.
- R5: A read returns the word selected by address bits [ADDR_W-1:2]: 0 is the mask, 1 is raw pending, 2 is masked pending, and 3 is NMI status. Every other index reads 0.
- R6: When no masked bit is set, `irq_req_o` is 0 and `irq_vec_o` is 0x00.
- R7: When exactly one masked bit i is set, `irq_req_o` is 1 and `irq_vec_o` is 0x31 + i.
- R8: When two or more masked bits are set, `irq_req_o` is 1 and `irq_vec_o` is 0x30.
- R9: NMI status bit 0 follows line 30 and bit 1 follows line 31. `nmi_o` is 1 exactly when a status bit is set. These lines never change `irq_req_o` or `irq_vec_o`, even when mask bits 30 and 31 are set.
- R10: A change on a line, or a mask write, presented before a rising edge reaches `irq_req_o`, `irq_vec_o`, `nmi_o` and the read data at that edge. Before that edge the outputs keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 32 | Interrupt levels; 0..29 maskable, 30..31 non-maskable |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for `bus_addr`, combinational |
| irq_req_o | output | 1 | Maskable interrupt request |
| irq_vec_o | output | 8 | Vector code |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Any stimulus presented before a rising edge appears in the raw, masked and NMI words, the request, the vector and `nmi_o` at that edge. A new read address reaches `bus_rd_data` in the same cycle, with no edge in between. The bench drives inputs on falling edges and samples 5 ns after each rising edge, once everything has settled. At that point it compares against a behavioural model that was advanced on the same edge. For the latency requirement, the bench also samples just before the edge to confirm that the old values still hold.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORD_W = 32;

  // Register word indices; software decodes these positions.
  typedef enum logic [1:0] {
    IDX_MASK   = 2'd0,
    IDX_RAW    = 2'd1,
    IDX_MASKED = 2'd2,
    IDX_NMI    = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/vic_line_capture.sv
module vic_line_capture #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_NMI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] lines,
  output logic [N_SRC-1:0] raw_next,
  output logic [N_NMI-1:0] nmi_next,
  output logic [N_SRC-1:0] raw_q,
  output logic [N_NMI-1:0] nmi_q
);
  localparam int unsigned N_MASKABLE = N_SRC - N_NMI;

  // The top lines are diverted to the non-maskable path.
  for (genvar g = 0; g < N_SRC; g++) begin : g_route
    if (g < N_MASKABLE) begin : g_mask_line
      assign raw_next[g] = lines[g];
    end else begin : g_nmi_line
      assign raw_next[g]             = 1'b0;
      assign nmi_next[g-N_MASKABLE]  = lines[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      nmi_q <= '0;
    end else begin
      raw_q <= raw_next;
      nmi_q <= nmi_next;
    end
  end
endmodule

// File: rtl/vic_mask_reg.sv
module vic_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_next,
  output logic [W-1:0] mask_q
);
  assign mask_next = wr_hit ? wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next;
  end
endmodule

// File: rtl/vic_vec_enc.sv
module vic_vec_enc #(
  parameter int unsigned N          = 32,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned SHARED_VEC = 'h30,
  parameter int unsigned BASE_VEC   = 'h31
) (
  input  logic [N-1:0]     pending,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic             any_set;
  logic             multi_set;
  logic [VEC_W-1:0] single_idx;

  assign any_set   = |pending;
  // Clearing the lowest set bit leaves something only if two or more were set.
  assign multi_set = |(pending & (pending - N'(1)));

  always_comb begin
    single_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pending[i]) single_idx = VEC_W'(i);
    end
  end

  always_comb begin
    req = any_set;
    if (!any_set)       vec = '0;
    else if (multi_set) vec = VEC_W'(SHARED_VEC);
    else                vec = VEC_W'(BASE_VEC) + single_idx;
  end
endmodule

// File: rtl/vic_nmi_top.sv
module vic_nmi_top #(
  parameter int unsigned N_SRC      = 32,
  parameter int unsigned N_NMI      = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned SHARED_VEC = 'h30,
  parameter int unsigned BASE_VEC   = 'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wr_data,
  output logic [31:0]       bus_rd_data,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              nmi_o
);
  import vic_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic [N_SRC-1:0] raw_next, raw_q, mask_next, mask_q, masked_next, masked_q;
  logic [N_NMI-1:0] nmi_next, nmi_q;
  logic             req_next;
  logic [VEC_W-1:0] vec_next;

  assign word_idx = bus_addr[ADDR_W-1:2];

  vic_line_capture #(.N_SRC(N_SRC), .N_NMI(N_NMI)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .lines    (irq_lines),
    .raw_next (raw_next),
    .nmi_next (nmi_next),
    .raw_q    (raw_q),
    .nmi_q    (nmi_q)
  );

  vic_mask_reg #(.W(N_SRC)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (bus_wr_en && word_idx == IDX_W'(IDX_MASK)),
    .wr_data   (bus_wr_data[N_SRC-1:0]),
    .mask_next (mask_next),
    .mask_q    (mask_q)
  );

  assign masked_next = raw_next & mask_next;
  assign masked_q    = raw_q & mask_q;

  // The encoder looks at the next state so that the registered outputs
  // agree with the pending words stored at the same edge.
  vic_vec_enc #(
    .N(N_SRC), .VEC_W(VEC_W), .SHARED_VEC(SHARED_VEC), .BASE_VEC(BASE_VEC)
  ) u_enc (
    .pending (masked_next),
    .req     (req_next),
    .vec     (vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
      nmi_o     <= 1'b0;
    end else begin
      irq_req_o <= req_next;
      irq_vec_o <= vec_next;
      nmi_o     <= |nmi_next;
    end
  end

  always_comb begin
    bus_rd_data = '0;
    if (word_idx == IDX_W'(IDX_MASK))        bus_rd_data = 32'(mask_q);
    else if (word_idx == IDX_W'(IDX_RAW))    bus_rd_data = 32'(raw_q);
    else if (word_idx == IDX_W'(IDX_MASKED)) bus_rd_data = 32'(masked_q);
    else if (word_idx == IDX_W'(IDX_NMI))    bus_rd_data = 32'(nmi_q);
  end
endmodule

// File: rtl/vic_nmi_chk.sv
module vic_nmi_chk #(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned N_NMI    = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned SHARED_VEC = 'h30,
  parameter int unsigned BASE_VEC = 'h31
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  lines,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [N_SRC-1:0]  raw,
  input logic [N_SRC-1:0]  mask,
  input logic [N_NMI-1:0]  nmi_stat,
  input logic              irq_req,
  input logic [VEC_W-1:0]  vec,
  input logic              nmi_out
);
  localparam int unsigned N_MASKABLE = N_SRC - N_NMI;

  logic [N_SRC-1:0] masked;
  logic [N_SRC-1:0] sel;
  assign masked = raw & mask;
  assign sel    = N_SRC'(1) << (vec - VEC_W'(BASE_VEC));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> raw[N_MASKABLE-1:0] == $past(lines[N_MASKABLE-1:0]));

  assert_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:2] != '0) |=> $stable(mask));

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    masked == '0 |-> (!irq_req && vec == '0));

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(masked) == 1 |->
      (irq_req && vec >= VEC_W'(BASE_VEC) && (masked & sel) == sel));

  assert_shared_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(masked) > 1 |-> (irq_req && vec == VEC_W'(SHARED_VEC)));

  assert_nmi_level_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_out == (nmi_stat != '0));

  assert_nmi_isolated_R9: assert property (@(posedge clk) disable iff (rst)
    raw[N_SRC-1:N_MASKABLE] == '0);
endmodule

bind vic_nmi_top vic_nmi_chk #(
  .N_SRC(N_SRC), .N_NMI(N_NMI), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .SHARED_VEC(SHARED_VEC), .BASE_VEC(BASE_VEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lines    (irq_lines),
  .addr     (bus_addr),
  .wr_en    (bus_wr_en),
  .raw      (raw_q),
  .mask     (mask_q),
  .nmi_stat (nmi_q),
  .irq_req  (irq_req_o),
  .vec      (irq_vec_o),
  .nmi_out  (nmi_o)
);

// File: tb/test_vic_nmi_top.sv
module test_vic_nmi_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lines = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        req;
  logic [7:0]  vec;
  logic        nmi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vic_nmi_top i_vic_nmi_top (
    .clk(clk), .rst(rst), .irq_lines(lines), .bus_addr(addr),
    .bus_wr_en(wr_en), .bus_wr_data(wdata), .bus_rd_data(rd_data),
    .irq_req_o(req), .irq_vec_o(vec), .nmi_o(nmi)
  );

  // Behavioural reference, advanced on each rising edge.
  logic [31:0] m_mask = '0, m_raw = '0, m_nmi = '0;
  logic        m_req = 1'b0;
  logic [7:0]  m_vec = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_raw = '0; m_nmi = '0; m_req = 1'b0; m_vec = '0;
    end else begin
      int cnt;
      int pos;
      logic [31:0] mk;
      if (wr_en && addr[7:2] == 6'd0) m_mask = wdata;
      m_raw = lines & 32'h3FFF_FFFF;
      m_nmi = {30'd0, lines[31:30]};
      mk = m_raw & m_mask;
      cnt = 0; pos = 0;
      for (int i = 0; i < 32; i++) if (mk[i]) begin cnt++; pos = i; end
      m_req = (cnt != 0);
      m_vec = (cnt == 0) ? 8'h00 : (cnt == 1) ? 8'(8'h31 + pos) : 8'h30;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a[7:2])
      6'd0: return m_mask;
      6'd1: return m_raw;
      6'd2: return m_raw & m_mask;
      6'd3: return m_nmi;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model 5 ns after every rising edge.
  always @(posedge clk) begin
    #5;
    if (!done) begin
      int c;
      c = $countones(m_raw & m_mask);
      if (rst) check("R1 req", {31'd0, req}, 32'd0);
      else if (c == 0) check("R6 req/vec", {23'd0, req, vec}, {23'd0, m_req, m_vec});
      else if (c == 1) check("R7 req/vec", {23'd0, req, vec}, {23'd0, m_req, m_vec});
      else             check("R8 req/vec", {23'd0, req, vec}, {23'd0, m_req, m_vec});
      check("R9 nmi", {31'd0, nmi}, {31'd0, m_nmi != 0});
      case (addr[7:2])
        6'd0: check("R4 rd mask", rd_data, m_read(addr));
        6'd1: check("R2 rd raw", rd_data, m_read(addr));
        6'd2: check("R3 rd masked", rd_data, m_read(addr));
        6'd3: check("R9 rd nmi", rd_data, m_read(addr));
        default: check("R5 rd unmapped", rd_data, m_read(addr));
      endcase
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  // Change the address at a falling edge and read in the same cycle.
  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  task automatic set_lines(input logic [31:0] v);
    lines = v; step();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 reset vec", {24'd0, vec}, 32'd0);
    rst = 1'b0;
    step();
    read_chk("R1 mask after reset", 8'h00, 32'd0);
    read_chk("R1 raw after reset", 8'h04, 32'd0);
    read_chk("R1 masked after reset", 8'h08, 32'd0);
    read_chk("R1 nmi after reset", 8'h0C, 32'd0);

    bus_write(8'h00, 32'hFFFF_FFFF);
    read_chk("R4 mask written", 8'h00, 32'hFFFF_FFFF);
    set_lines(32'h0000_0020);
    check("R7 line5 vec", {24'd0, vec}, 32'h36);
    check("R7 line5 req", {31'd0, req}, 32'd1);
    set_lines(32'h0000_0220);
    check("R8 two lines vec", {24'd0, vec}, 32'h30);
    read_chk("R3 masked two", 8'h08, 32'h0000_0220);
    set_lines(32'h2000_0000);
    check("R7 line29 vec", {24'd0, vec}, 32'h4E);
    set_lines(32'h0000_0001);
    check("R7 line0 vec", {24'd0, vec}, 32'h31);

    bus_write(8'h00, 32'h0000_0000);
    check("R6 masked off req", {31'd0, req}, 32'd0);
    check("R6 masked off vec", {24'd0, vec}, 32'd0);
    read_chk("R2 raw still set", 8'h04, 32'h0000_0001);

    bus_write(8'h00, 32'h0000_0100);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h0D, 32'hFFFF_FFFF);
    read_chk("R4 mask unchanged", 8'h00, 32'h0000_0100);
    read_chk("R4 raw unchanged", 8'h04, 32'h0000_0001);
    read_chk("R5 unmapped 0x10", 8'h10, 32'd0);
    read_chk("R5 unmapped 0xFC", 8'hFC, 32'd0);
    read_chk("R5 low bits ignored", 8'h03, 32'h0000_0100);

    bus_write(8'h00, 32'hFFFF_FFFF);
    set_lines(32'h4000_0000);
    check("R9 line30 nmi", {31'd0, nmi}, 32'd1);
    check("R9 line30 no req", {31'd0, req}, 32'd0);
    read_chk("R9 status line30", 8'h0C, 32'd1);
    read_chk("R2 raw bit30 zero", 8'h04, 32'd0);
    set_lines(32'h8000_0000);
    read_chk("R9 status line31", 8'h0C, 32'd2);
    set_lines(32'h0000_0000);
    check("R9 nmi cleared", {31'd0, nmi}, 32'd0);

    // Latency: old values hold until the capturing edge.
    lines = 32'h0000_0008;
    @(posedge clk); #(-0); 
    check("R10 before edge req", {31'd0, req}, 32'd0);
    #5;
    check("R10 after edge vec", {24'd0, vec}, 32'h34);
    step();
    addr = 8'h00; wr_en = 1'b1; wdata = 32'd0;
    #5;
    check("R10 mask write pending req", {31'd0, req}, 32'd1);
    @(posedge clk); #5;
    check("R10 mask write applied req", {31'd0, req}, 32'd0);
    step();
    wr_en = 1'b0;

    for (int k = 0; k < 400; k++) begin
      lines = $urandom();
      if (k % 4 == 0) lines = lines & (32'h1 << ($urandom() % 32));
      wr_en = ($urandom() % 5) == 0;
      addr = 8'($urandom() % 24);
      wdata = ($urandom() % 2) ? $urandom() : (32'h1 << ($urandom() % 32));
      step();
    end
    wr_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule